// File: doc/BRIEF.md
# Constant On-Time Buck Switching Sequencer

This block decides, cycle by cycle, when the high-side and low-side switches of a valley-regulated buck converter are commanded on. It has no switching clock of its own. It reacts to six comparator results that have already been digitised, to an on-time length that another block computes, to a mode flag raised while the output voltage code is changing, and to a fault-force flag from the protection logic.

A high-side pulse starts when three things are true: the output has sagged below its target, a minimum off interval has passed, and the inductor valley current is under its limit. The pulse then runs for the full programmed length, whatever the feedback comparator does. Control then passes to the low side. In normal mode the low side ends at the current zero crossing, which gives pulse-skipping at light load. In transition mode the zero crossing is ignored, and a negative current limit sends the block into a timed hold in which both switches are off.

Each handover waits for an interlock input, so the two switches never conduct together. The design uses these interlocks in place of fixed dead times.

Top module: `cot_buck_sequencer`

## Requirements
- R1: The block leaves the off state toward a high-side pulse (both outputs low, waiting for the low-gate interlock) only on an edge where fb_low=1, ilim_pos=0, the minimum off interval has elapsed, and fault_force=0. While fb_low=0 or ilim_pos=1, the low side stays on.
- R2: hs_en stays high for exactly ton_cycles clock cycles, and a ton_cycles value of 0 is treated as 1. Toggling fb_low during the pulse has no effect on its length.
- R3: After hs_en falls on an edge, no new turn-on decision is taken before TOFF_MIN further edges have passed. At the default of 50 cycles this is 500 ns at 100 MHz.
- R4: When the on-time expires, hs_en falls. After the phase interlock is seen, ls_en rises.
- R5: In normal mode (trans_mode=0), zero_x=1 during low-side conduction turns ls_en off, and both outputs stay low until the next pulse. If zero_x stays 0, ls_en stays high until the next turn-on.
- R6: In transition mode (trans_mode=1), zero_x has no effect. ilim_neg=1 during low-side conduction turns both outputs off for ton_cycles cycles, even if ilim_neg clears at once.
- R7: When that hold ends, the block heads for a high-side pulse if R1's turn-on condition holds. Otherwise it heads back to the low side through the phase interlock.
- R8: ls_en rises only on an edge where phase_low=1 was sampled, unless fault_force=1 was sampled while both outputs were already off.
- R9: hs_en rises only on an edge where lgate_low=1 was sampled.
- R10: fault_force=1 turns hs_en off on the next edge and holds ls_en on (reached through the phase interlock when the high side was conducting). Turn-on is blocked until fault_force returns to 0.
- R11: While rst=1 and on the first edge after it, hs_en=0 and ls_en=1. The minimum off interval counts as already elapsed at start-up.
- R12: hs_en and ls_en are never both 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_low | input | 1 | 1 when the fed-back output is below the reference |
| ilim_pos | input | 1 | 1 when the valley current exceeds the positive limit |
| ilim_neg | input | 1 | 1 when the reverse current exceeds the negative limit |
| zero_x | input | 1 | 1 when the inductor current has fallen to zero |
| phase_low | input | 1 | 1 when the switch node is near ground |
| lgate_low | input | 1 | 1 when the low-side gate has discharged |
| ton_cycles | input | TON_W | Programmed on-time in clock cycles |
| trans_mode | input | 1 | 1 while the output voltage code is changing |
| fault_force | input | 1 | 1 forces the latched-fault switch pattern |
| hs_en | output | 1 | High-side switch command |
| ls_en | output | 1 | Low-side switch command |

## Verification
Several functions can claim the same edge, and the bench drives each pair on purpose.

- **Turn-on against a blocker.** A turn-on request is held against a positive current-limit trip, and against a fault-force. The low side must keep conducting until the blocker clears.
- **Zero crossing against transition mode.** A zero crossing arrives while transition mode is set, and it must be overridden.
- **Fault during a pulse.** Fault-force is raised in the middle of a high-side pulse, and it must cut the pulse short while the phase interlock is still honoured.

Each outcome is judged by queued expected drive pairs that a monitor compares 3 ns after every clock edge. A separate per-cycle check confirms that the two drives never overlap.

// File: rtl/cot_pkg.sv
package cot_pkg;

    // Sequencer states; the comment gives the drive pattern (hs/ls).
    typedef enum logic [2:0] {
        ST_LS_ON    = 3'd0,  // 0/1 low side conducting, off time
        ST_IDLE     = 3'd1,  // 0/0 skipped after zero crossing
        ST_NEG_HOLD = 3'd2,  // 0/0 negative-limit hold
        ST_WAIT_LG  = 3'd3,  // 0/0 waiting for low gate to discharge
        ST_HS_ON    = 3'd4,  // 1/0 on-time running
        ST_WAIT_PH  = 3'd5,  // 0/0 waiting for switch node to fall
        ST_FAULT    = 3'd6   // 0/1 latched fault pattern
    } seq_state_e;

    // Digitised comparator results.
    typedef struct packed {
        logic fb_low;
        logic ilim_pos;
        logic ilim_neg;
        logic zero_x;
        logic phase_low;
        logic lgate_low;
    } cmp_bus_t;

    function automatic logic drives_hs(input seq_state_e s);
        return s == ST_HS_ON;
    endfunction

    function automatic logic drives_ls(input seq_state_e s);
        return (s == ST_LS_ON) || (s == ST_FAULT);
    endfunction

endpackage

// File: rtl/cot_interval_timer.sv
// Loadable down-counter. done is high while the count is zero.
module cot_interval_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/cot_turnon_qual.sv
// Three-way qualification for a new high-side pulse.
module cot_turnon_qual
    import cot_pkg::*;
(
    input  cmp_bus_t cmp,
    input  logic     off_done,
    input  logic     fault_force,
    output logic     turn_on_ok
);
    always_comb begin
        turn_on_ok = cmp.fb_low && off_done && !cmp.ilim_pos && !fault_force;
    end
endmodule

// File: rtl/cot_seq_fsm.sv
// Switching state machine: on-time, off-time modes and interlocked handover.
module cot_seq_fsm
    import cot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cmp_bus_t   cmp,
    input  logic       trans_mode,
    input  logic       fault_force,
    input  logic       turn_on_ok,
    input  logic       ton_done,
    output seq_state_e state_q,
    output logic       ton_load,
    output logic       off_load
);
    seq_state_e state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_LS_ON: begin
                if (fault_force)                         state_d = ST_FAULT;
                else if (turn_on_ok)                     state_d = ST_WAIT_LG;
                else if (trans_mode && cmp.ilim_neg)     state_d = ST_NEG_HOLD;
                else if (!trans_mode && cmp.zero_x)      state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (fault_force)                         state_d = ST_FAULT;
                else if (turn_on_ok)                     state_d = ST_WAIT_LG;
            end
            ST_NEG_HOLD: begin
                if (fault_force)                         state_d = ST_FAULT;
                else if (ton_done)                       state_d = turn_on_ok ? ST_WAIT_LG : ST_WAIT_PH;
            end
            ST_WAIT_LG: begin
                if (fault_force)                         state_d = ST_FAULT;
                else if (cmp.lgate_low)                  state_d = ST_HS_ON;
            end
            ST_HS_ON: begin
                if (fault_force || ton_done)             state_d = ST_WAIT_PH;
            end
            ST_WAIT_PH: begin
                if (cmp.phase_low)                       state_d = fault_force ? ST_FAULT : ST_LS_ON;
            end
            ST_FAULT: begin
                if (!fault_force)                        state_d = ST_LS_ON;
            end
            default:                                     state_d = ST_FAULT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_LS_ON;
        else     state_q <= state_d;
    end

    always_comb begin
        ton_load = (state_q != ST_HS_ON    && state_d == ST_HS_ON) ||
                   (state_q != ST_NEG_HOLD && state_d == ST_NEG_HOLD);
        off_load = (state_q == ST_HS_ON) && (state_d != ST_HS_ON);
    end
endmodule

// File: rtl/cot_gate_drive.sv
// Decodes the sequencer state into the two switch commands.
module cot_gate_drive
    import cot_pkg::*;
(
    input  seq_state_e state,
    output logic       hs_en,
    output logic       ls_en
);
    always_comb begin
        hs_en = drives_hs(state);
        ls_en = drives_ls(state);
    end
endmodule

// File: rtl/cot_buck_sequencer.sv
module cot_buck_sequencer
    import cot_pkg::*;
#(
    parameter int TON_W    = 8,
    parameter int TOFF_MIN = 50
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fb_low,
    input  logic             ilim_pos,
    input  logic             ilim_neg,
    input  logic             zero_x,
    input  logic             phase_low,
    input  logic             lgate_low,
    input  logic [TON_W-1:0] ton_cycles,
    input  logic             trans_mode,
    input  logic             fault_force,
    output logic             hs_en,
    output logic             ls_en
);
    localparam int OFF_W = $clog2(TOFF_MIN + 1);

    cmp_bus_t         cmp;
    seq_state_e       state_q;
    logic             turn_on_ok;
    logic             ton_done;
    logic             off_done;
    logic             ton_load;
    logic             off_load;
    logic [TON_W-1:0] ton_reload;

    always_comb begin
        cmp.fb_low    = fb_low;
        cmp.ilim_pos  = ilim_pos;
        cmp.ilim_neg  = ilim_neg;
        cmp.zero_x    = zero_x;
        cmp.phase_low = phase_low;
        cmp.lgate_low = lgate_low;
        ton_reload    = (ton_cycles == '0) ? '0 : ton_cycles - TON_W'(1);
    end

    cot_interval_timer #(.W(TON_W)) u_ton_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (ton_load),
        .load_val (ton_reload),
        .done     (ton_done)
    );

    cot_interval_timer #(.W(OFF_W)) u_off_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (off_load),
        .load_val (OFF_W'(TOFF_MIN - 1)),
        .done     (off_done)
    );

    cot_turnon_qual u_qual (
        .cmp         (cmp),
        .off_done    (off_done),
        .fault_force (fault_force),
        .turn_on_ok  (turn_on_ok)
    );

    cot_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cmp         (cmp),
        .trans_mode  (trans_mode),
        .fault_force (fault_force),
        .turn_on_ok  (turn_on_ok),
        .ton_done    (ton_done),
        .state_q     (state_q),
        .ton_load    (ton_load),
        .off_load    (off_load)
    );

    cot_gate_drive u_drive (
        .state (state_q),
        .hs_en (hs_en),
        .ls_en (ls_en)
    );
endmodule

// File: rtl/cot_buck_sequencer_chk.sv
module cot_buck_sequencer_chk
    import cot_pkg::*;
#(
    parameter int TOFF_MIN = 50
) (
    input logic       clk,
    input logic       rst,
    input logic       hs_en,
    input logic       ls_en,
    input logic       lgate_low,
    input logic       phase_low,
    input logic       fault_force,
    input logic       ilim_pos,
    input seq_state_e state
);
    localparam int GAP_W = $clog2(TOFF_MIN + 1) + 1;

    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst)                           gap_q <= GAP_W'(TOFF_MIN);
        else if (hs_en)                    gap_q <= '0;
        else if (gap_q < GAP_W'(TOFF_MIN)) gap_q <= gap_q + GAP_W'(1);
    end

    // R12
    gates_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(hs_en && ls_en));

    // R9
    hs_after_lgate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_en) |-> $past(lgate_low));

    // R8
    ls_after_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ls_en) |-> ($past(phase_low) || $past(fault_force)));

    // R10
    fault_hs_off_chk: assert property (@(posedge clk) disable iff (rst)
        fault_force |=> !hs_en);

    // R3
    min_off_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_en) |-> (gap_q >= GAP_W'(TOFF_MIN)));

    // R1
    ilim_block_chk: assert property (@(posedge clk) disable iff (rst)
        (ilim_pos && (state == ST_LS_ON || state == ST_IDLE || state == ST_NEG_HOLD))
        |=> (state != ST_WAIT_LG));
endmodule

bind cot_buck_sequencer cot_buck_sequencer_chk #(.TOFF_MIN(TOFF_MIN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .hs_en       (hs_en),
    .ls_en       (ls_en),
    .lgate_low   (lgate_low),
    .phase_low   (phase_low),
    .fault_force (fault_force),
    .ilim_pos    (ilim_pos),
    .state       (state_q)
);

// File: tb/cot_buck_sequencer_bench.sv
module cot_buck_sequencer_bench;
    localparam int TON_W    = 8;
    localparam int TOFF_MIN = 50;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             fb_low = 1'b0, ilim_pos = 1'b0, ilim_neg = 1'b0, zero_x = 1'b0;
    logic             phase_low = 1'b0, lgate_low = 1'b0, trans_mode = 1'b0, fault_force = 1'b0;
    logic [TON_W-1:0] ton_cycles = 8'd4;
    logic             hs_en, ls_en;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    typedef struct {
        logic  hs;
        logic  ls;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk = ~clk;

    cot_buck_sequencer #(.TON_W(TON_W), .TOFF_MIN(TOFF_MIN)) u_cot_buck_sequencer (
        .clk(clk), .rst(rst), .fb_low(fb_low), .ilim_pos(ilim_pos), .ilim_neg(ilim_neg),
        .zero_x(zero_x), .phase_low(phase_low), .lgate_low(lgate_low),
        .ton_cycles(ton_cycles), .trans_mode(trans_mode), .fault_force(fault_force),
        .hs_en(hs_en), .ls_en(ls_en)
    );

    // Monitor: compares the queued expectation 3 ns after each edge.
    always @(posedge clk) begin
        #3;
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (hs_en !== e.hs || ls_en !== e.ls) begin
                errors++;
                $display("FAIL %s: hs/ls actual %b/%b expected %b/%b at %0t",
                         e.tag, hs_en, ls_en, e.hs, e.ls, $time);
            end
        end
    end

    // R12: drives never overlap, checked every cycle.
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (hs_en && ls_en) begin
                errors++;
                $display("FAIL R12: hs/ls actual 1/1 expected not both at %0t", $time);
            end
        end
    end

    // Driver: called at a negedge; the expectation applies after the next edge.
    task automatic step(input logic hs, input logic ls, input string tag);
        exp_t e;
        e.hs = hs; e.ls = ls; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    // Starts from the state waiting for the low gate; n is the effective on-time.
    task automatic pulse(input int n);
        lgate_low = 1'b1; phase_low = 1'b0;
        step(1'b1, 1'b0, "R9");
        lgate_low = 1'b0;
        for (int i = 1; i < n; i++) begin
            fb_low = ~fb_low;
            step(1'b1, 1'b0, "R2");
        end
        fb_low = 1'b0;
        step(1'b0, 1'b0, "R4");
        step(1'b0, 1'b0, "R8");
        phase_low = 1'b1;
        step(1'b0, 1'b1, "R4");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        step(1'b0, 1'b1, "R11");
        rst = 1'b0;
        step(1'b0, 1'b1, "R11");
        step(1'b0, 1'b1, "R1");            // fb_low=0 keeps low side on

        // First pulse, interlock wait on the low gate.
        fb_low = 1'b1;
        step(1'b0, 1'b0, "R1");
        step(1'b0, 1'b0, "R9");
        pulse(4);

        // Minimum off interval with the turn-on request held high.
        fb_low = 1'b1;
        repeat (TOFF_MIN - 3) step(1'b0, 1'b1, "R3");
        step(1'b0, 1'b0, "R3");
        ton_cycles = 8'd2;
        pulse(2);

        // No zero crossing: the low side holds; then positive-limit blocking.
        repeat (TOFF_MIN) step(1'b0, 1'b1, "R5");
        ilim_pos = 1'b1; fb_low = 1'b1;
        repeat (3) step(1'b0, 1'b1, "R1");
        ilim_pos = 1'b0;
        step(1'b0, 1'b0, "R1");
        ton_cycles = 8'd0;
        pulse(1);

        // Zero crossing ends low-side conduction in normal mode.
        zero_x = 1'b1;
        step(1'b0, 1'b0, "R5");
        zero_x = 1'b0;
        step(1'b0, 1'b0, "R5");
        repeat (TOFF_MIN) step(1'b0, 1'b0, "R5");
        fb_low = 1'b1;
        step(1'b0, 1'b0, "R1");
        ton_cycles = 8'd3;
        pulse(3);

        // Transition mode: zero crossing ignored, negative-limit hold.
        trans_mode = 1'b1; zero_x = 1'b1;
        repeat (3) step(1'b0, 1'b1, "R6");
        zero_x = 1'b0;
        repeat (TOFF_MIN) step(1'b0, 1'b1, "R6");
        ton_cycles = 8'd4;
        ilim_neg = 1'b1;
        step(1'b0, 1'b0, "R6");
        ilim_neg = 1'b0;
        repeat (3) step(1'b0, 1'b0, "R6");
        step(1'b0, 1'b0, "R7");
        step(1'b0, 1'b1, "R7");
        ilim_neg = 1'b1;
        step(1'b0, 1'b0, "R6");
        ilim_neg = 1'b0;
        step(1'b0, 1'b0, "R6");
        step(1'b0, 1'b0, "R6");
        fb_low = 1'b1;
        step(1'b0, 1'b0, "R6");
        step(1'b0, 1'b0, "R7");
        pulse(4);
        trans_mode = 1'b0;
        repeat (TOFF_MIN) step(1'b0, 1'b1, "R5");

        // Fault while the low side conducts, with turn-on requested.
        fault_force = 1'b1;
        step(1'b0, 1'b1, "R10");
        fb_low = 1'b1;
        repeat (2) step(1'b0, 1'b1, "R10");
        fault_force = 1'b0;
        step(1'b0, 1'b1, "R10");
        step(1'b0, 1'b0, "R1");

        // Fault in the middle of a high-side pulse.
        ton_cycles = 8'd6;
        lgate_low = 1'b1;
        step(1'b1, 1'b0, "R9");
        fault_force = 1'b1; lgate_low = 1'b0; phase_low = 1'b0;
        step(1'b0, 1'b0, "R10");
        step(1'b0, 1'b0, "R8");
        phase_low = 1'b1;
        step(1'b0, 1'b1, "R10");
        fault_force = 1'b0; fb_low = 1'b0;
        step(1'b0, 1'b1, "R10");

        // Fault entered from the skipped state.
        zero_x = 1'b1;
        step(1'b0, 1'b0, "R5");
        zero_x = 1'b0; fault_force = 1'b1;
        step(1'b0, 1'b1, "R10");
        fault_force = 1'b0;
        step(1'b0, 1'b1, "R10");

        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule